// File: doc/BRIEF.md
# End-of-List Polling Controller

This controller sits in a queue manager that walks chains of descriptor block wrappers. When the walker reports that it has hit the end of a chain, the controller decides what to do next. A 2-bit policy code, latched when the end-of-list event is accepted, selects one of three behaviours:

- keep polling the last wrapper until it reports a non-zero size;
- notify the upper message queue at once;
- poll up to a programmed number of times and then notify.

Consecutive polls are separated by a programmable gap, counted in cycles. Each poll waits for a completion strobe that carries the wrapper size that was read back.

Independently of polling, the controller keeps a refill request asserted with hysteresis. The request switches on when the count of free entries drops to a low threshold. It switches off once the count climbs to a high threshold.

Top module: `eol_poll_ctrl`

## Requirements
- R1: While reset is held, `poll_req`, `msg_send` and `refill_active` are all 0.
- R2: With policy 2'b00, a zero wrapper size always leads to another poll, whatever `max_polls` holds. `msg_send` never rises under this policy.
- R3: With policy 2'b01, an accepted end-of-list event raises `msg_send` in the next cycle, and no poll is issued.
- R4: With policy 2'b10 or 2'b11 and `max_polls` = N > 0, at most N polls are issued. If all N of them return size 0, `msg_send` rises in the cycle after the Nth `poll_done` is sampled.
- R5: With policy 2'b10 or 2'b11 and `max_polls` = 0, an accepted event raises `msg_send` in the next cycle, and no poll is issued.
- R6: A `poll_done` carrying a non-zero `wrap_size` ends the sequence with no message and returns to idle. It also clears the poll count, so the next event gets the full `max_polls` budget.
- R7: `poll_req` is a one-cycle pulse.
  - The first poll is raised `poll_gap`+1 cycles after the accepting edge.
  - After a zero-size completion, the next poll is raised `poll_gap`+1 cycles after the edge that sampled `poll_done`.
- R8: `msg_send` is a one-cycle pulse, after which the controller is idle. A new end-of-list event is needed before anything further is issued.
- R9: On the edge after `free_cnt` <= `refill_lo` is sampled, `refill_active` is 1.
- R10: On the edge after `free_cnt` >= `refill_hi` (with `free_cnt` > `refill_lo`) is sampled, `refill_active` is 0. Strictly between the two thresholds it keeps its previous value.
- R11: `eol_evt` is ignored while a polling sequence is in progress. The pulses already due are unchanged and none are added.

Each poll that returns a zero size also counts one try; that count is what R4 compares against `max_polls`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eol_evt | input | 1 | Walker reached end of list (accepted only when idle) |
| policy | input | 2 | End-of-list policy: 00 poll forever, 01 message now, 1x bounded polling |
| max_polls | input | CNT_W | Number of zero-size polls allowed before messaging |
| poll_gap | input | GAP_W | Idle cycles inserted before each poll |
| poll_done | input | 1 | Poll completion strobe |
| wrap_size | input | SIZE_W | Wrapper size returned with `poll_done` |
| free_cnt | input | FREE_W | Current free-entry count |
| refill_lo | input | FREE_W | Refill switch-on threshold |
| refill_hi | input | FREE_W | Refill switch-off threshold |
| poll_req | output | 1 | One-cycle request to re-read the last wrapper |
| msg_send | output | 1 | One-cycle request toward the upper message queue |
| refill_active | output | 1 | Refill request, with hysteresis |

## Verification
All three outputs come from registers, so each result is due a fixed number of edges after its cause:

- an immediate message appears one cycle after the event edge;
- a poll appears `poll_gap`+1 cycles after the event edge or the completion edge;
- a refill change appears one cycle after the free count is sampled.

The bench answers each poll request two cycles after seeing it. From that rule the driver works out the exact cycle and kind of every pulse and queues them before firing the event. The monitor compares each observed pulse against the head of that queue on the falling edge. Refill results are sampled one falling edge after the count changes.

// File: rtl/eol_poll_pkg.sv
package eol_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_REQ,
    ST_WAIT,
    ST_MSG
  } eol_state_e;

  // Hysteresis step: low threshold wins, high threshold releases, else hold.
  function automatic logic refill_next(input logic cur, input int unsigned free,
                                       input int unsigned lo, input int unsigned hi);
    if (free <= lo)      return 1'b1;
    else if (free >= hi) return 1'b0;
    else                 return cur;
  endfunction

  // True once the number of zero-size polls reaches the allowed budget.
  function automatic logic tries_spent(input int unsigned tries_after,
                                       input int unsigned budget);
    return tries_after >= budget;
  endfunction

endpackage

// File: rtl/eol_gap_timer.sv
module eol_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= gap;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eol_try_counter.sv
module eol_try_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr)                      cnt_q <= '0;
    else if (inc && (cnt_q != '1))     cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/eol_refill_hyst.sv
module eol_refill_hyst
  import eol_poll_pkg::*;
#(
  parameter int FREE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] free_cnt,
  input  logic [FREE_W-1:0] lo_thr,
  input  logic [FREE_W-1:0] hi_thr,
  output logic              active
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= refill_next(act_q, 32'(free_cnt), 32'(lo_thr), 32'(hi_thr));
  end

  assign active = act_q;
endmodule

// File: rtl/eol_poll_ctrl.sv
module eol_poll_ctrl
  import eol_poll_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 8,
  parameter int FREE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eol_evt,
  input  logic [1:0]        policy,
  input  logic [CNT_W-1:0]  max_polls,
  input  logic [GAP_W-1:0]  poll_gap,
  input  logic              poll_done,
  input  logic [SIZE_W-1:0] wrap_size,
  input  logic [FREE_W-1:0] free_cnt,
  input  logic [FREE_W-1:0] refill_lo,
  input  logic [FREE_W-1:0] refill_hi,
  output logic              poll_req,
  output logic              msg_send,
  output logic              refill_active
);
  localparam logic [1:0] POL_FOREVER = 2'b00;
  localparam logic [1:0] POL_NOTIFY  = 2'b01;

  eol_state_e       state_q, state_d;
  logic [1:0]       pol_q;
  logic             gap_load, gap_expired;
  logic             try_clr, try_inc;
  logic [CNT_W-1:0] try_cnt;

  // Named events for the checker
  logic st_idle, evt_accept, poll_hit, poll_miss, budget_out;

  assign st_idle    = (state_q == ST_IDLE);
  assign evt_accept = st_idle && eol_evt;
  assign poll_hit   = (state_q == ST_WAIT) && poll_done && (wrap_size != '0);
  assign poll_miss  = (state_q == ST_WAIT) && poll_done && (wrap_size == '0);
  assign budget_out = pol_q[1] && tries_spent(32'(try_cnt) + 32'd1, 32'(max_polls));

  eol_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .gap(poll_gap), .expired(gap_expired)
  );

  eol_try_counter #(.CNT_W(CNT_W)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .count(try_cnt)
  );

  eol_refill_hyst #(.FREE_W(FREE_W)) u_refill (
    .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .lo_thr(refill_lo),
    .hi_thr(refill_hi), .active(refill_active)
  );

  always_comb begin
    state_d  = state_q;
    gap_load = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (eol_evt) begin
          try_clr = 1'b1;
          if (policy == POL_NOTIFY || (policy[1] && max_polls == '0)) begin
            state_d = ST_MSG;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end
        end
      end
      ST_GAP:  if (gap_expired) state_d = ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (poll_hit) begin
          state_d = ST_IDLE;
          try_clr = 1'b1;
        end else if (poll_miss) begin
          if (budget_out) begin
            state_d = ST_MSG;
            try_clr = 1'b1;
          end else begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
            try_inc  = 1'b1;
          end
        end
      end
      ST_MSG:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pol_q   <= POL_FOREVER;
    end else begin
      state_q <= state_d;
      if (evt_accept) pol_q <= policy;
    end
  end

  assign poll_req = (state_q == ST_REQ);
  assign msg_send = (state_q == ST_MSG);
endmodule

// File: rtl/eol_poll_ctrl_chk.sv
module eol_poll_ctrl_chk #(
  parameter int CNT_W  = 8,
  parameter int FREE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eol_evt,
  input logic [1:0]        policy,
  input logic [CNT_W-1:0]  max_polls,
  input logic [FREE_W-1:0] free_cnt,
  input logic [FREE_W-1:0] refill_lo,
  input logic [FREE_W-1:0] refill_hi,
  input logic              poll_req,
  input logic              msg_send,
  input logic              refill_active,
  input logic              st_idle,
  input logic              poll_hit,
  input logic [1:0]        pol_q
);
  // R2
  forever_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q == 2'b00) |-> !msg_send);

  // R3
  notify_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && eol_evt && policy == 2'b01) |=> (msg_send && !poll_req));

  // R5
  zero_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && eol_evt && policy[1] && max_polls == '0) |=> msg_send);

  // R6
  hit_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_hit |=> (st_idle && !msg_send));

  // R7
  poll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> !poll_req);

  // R8
  msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_send |=> (!msg_send && st_idle));

  // R9
  refill_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt <= refill_lo) |=> refill_active);

  // R10
  refill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt >= refill_hi && free_cnt > refill_lo) |=> !refill_active);

  // R10
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt > refill_lo && free_cnt < refill_hi) |=> (refill_active == $past(refill_active)));
endmodule

bind eol_poll_ctrl eol_poll_ctrl_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eol_evt(eol_evt), .policy(policy), .max_polls(max_polls),
  .free_cnt(free_cnt), .refill_lo(refill_lo), .refill_hi(refill_hi),
  .poll_req(poll_req), .msg_send(msg_send), .refill_active(refill_active),
  .st_idle(st_idle), .poll_hit(poll_hit), .pol_q(pol_q)
);

// File: tb/eol_poll_ctrl_tb.sv
module eol_poll_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_W = 16, CNT_W = 8, GAP_W = 8, FREE_W = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n = 1'b0;
  logic              eol_evt = 1'b0;
  logic [1:0]        policy = 2'b00;
  logic [CNT_W-1:0]  max_polls = '0;
  logic [GAP_W-1:0]  poll_gap = '0;
  logic              poll_done = 1'b0;
  logic [SIZE_W-1:0] wrap_size = '0;
  logic [FREE_W-1:0] free_cnt = 10'd15;
  logic [FREE_W-1:0] refill_lo = 10'd10;
  logic [FREE_W-1:0] refill_hi = 10'd20;
  logic              poll_req, msg_send, refill_active;

  eol_poll_ctrl #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .GAP_W(GAP_W), .FREE_W(FREE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .eol_evt(eol_evt), .policy(policy), .max_polls(max_polls),
    .poll_gap(poll_gap), .poll_done(poll_done), .wrap_size(wrap_size),
    .free_cnt(free_cnt), .refill_lo(refill_lo), .refill_hi(refill_hi),
    .poll_req(poll_req), .msg_send(msg_send), .refill_active(refill_active)
  );

  typedef struct {
    int    at;
    bit    is_msg;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  int    size_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    pend = 1'b0;
  bit    ended = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor and poll responder: pulses compared against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (poll_req || msg_send) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected pulse (cycle*10+msg)", cyc*10 + int'(msg_send), -1);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(it.at == cyc && it.is_msg == msg_send && (poll_req != msg_send), it.req,
                "pulse (cycle*10+msg)", cyc*10 + int'(msg_send), it.at*10 + int'(it.is_msg));
        end
      end
      if (pend) begin
        poll_done = 1'b1;
        wrap_size = (size_q.size() != 0) ? SIZE_W'(size_q.pop_front()) : SIZE_W'(1);
        pend = 1'b0;
      end else begin
        poll_done = 1'b0;
      end
      if (poll_req) pend = 1'b1;
    end
  end

  task automatic run_eol(input logic [1:0] pol, input int maxp, input int gap,
                         input int sizes[$], input int extra_at, input string req);
    int   p, tries, e;
    exp_t it;
    @(negedge clk);
    cur_req   = req;
    policy    = pol;
    max_polls = CNT_W'(maxp);
    poll_gap  = GAP_W'(gap);
    e = cyc + 1;
    if (pol == 2'b01 || (pol[1] && maxp == 0)) begin
      it.at = e; it.is_msg = 1'b1; it.req = req; exp_q.push_back(it);
    end else begin
      p = e + gap + 1;
      tries = 0;
      foreach (sizes[i]) begin
        it.at = p; it.is_msg = 1'b0; it.req = req; exp_q.push_back(it);
        if (sizes[i] != 0) break;
        tries++;
        if (pol[1] && tries >= maxp) begin
          it.at = p + 2; it.is_msg = 1'b1; exp_q.push_back(it);
          break;
        end
        p = p + 2 + gap + 1;
      end
    end
    foreach (sizes[i]) size_q.push_back(sizes[i]);
    eol_evt = 1'b1;
    @(negedge clk);
    eol_evt = 1'b0;
    if (extra_at > 0) begin
      repeat (extra_at - 1) @(negedge clk);
      eol_evt = 1'b1;
      @(negedge clk);
      eol_evt = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (gap + 8) @(negedge clk);
    check(size_q.size() == 0, req, "unconsumed poll replies", size_q.size(), 0);
  endtask

  task automatic set_free(input int v, input bit expv, input string req);
    @(negedge clk);
    free_cnt = FREE_W'(v);
    @(negedge clk);
    check(refill_active == expv, req, "refill_active", int'(refill_active), int'(expv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(poll_req == 1'b0, "R1", "poll_req in reset", int'(poll_req), 0);
    check(msg_send == 1'b0, "R1", "msg_send in reset", int'(msg_send), 0);
    check(refill_active == 1'b0, "R1", "refill_active in reset", int'(refill_active), 0);
    rst_n = 1'b1;

    // Refill hysteresis: lo=10, hi=20
    set_free(15, 1'b0, "R10");
    set_free(10, 1'b1, "R9");
    set_free(15, 1'b1, "R10");
    set_free(19, 1'b1, "R10");
    set_free(20, 1'b0, "R10");
    set_free(5,  1'b1, "R9");
    set_free(12, 1'b1, "R10");
    set_free(30, 1'b0, "R10");
    set_free(50, 1'b0, "R10");

    // R2: forever polling ignores the budget
    run_eol(2'b00, 2, 2, '{0, 0, 0, 0, 5}, 0, "R2");
    // R3: immediate message
    run_eol(2'b01, 4, 3, '{}, 0, "R3");
    // R4 / R8: bounded polling then one message
    run_eol(2'b10, 3, 1, '{0, 0, 0}, 0, "R4/R8");
    run_eol(2'b11, 2, 0, '{0, 0}, 0, "R4");
    // R5: zero budget
    run_eol(2'b10, 0, 2, '{}, 0, "R5");
    // R6: hit ends the sequence; the budget is fresh next time
    run_eol(2'b10, 3, 1, '{0, 7}, 0, "R6");
    run_eol(2'b10, 3, 1, '{0, 0, 0}, 0, "R6");
    // R7: longer gap
    run_eol(2'b00, 1, 5, '{0, 9}, 0, "R7");
    // R11: event while busy is ignored
    run_eol(2'b00, 1, 4, '{0, 0, 3}, 3, "R11");

    check(refill_active == 1'b0, "R10", "refill_active after polling", int'(refill_active), 0);
    finish_sim();
  end
endmodule